// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block runs program, sector-erase and erase-verify operations on an embedded flash array. It also handles suspend, resume, clear-status and a pulse-limit setting. Each command arrives as a code, a word address and a data word on a valid/ready port. The block checks the address against the array map, the bank-select input and the one-time-programmable (OTP) unlock input. It then drives single-cycle requests to the array and waits for each acknowledge. The array is a behavioural model outside the block, and its request/acknowledge pair is a plain control handshake.

A program operation first reads the target word, then alternates pulses and verify reads. An erase operation alternates sector pulses and a full read-back of the sector. Both stop when verify passes or when the pulse limit is reached. The outcome is reported in a read-only 16-bit status word.

The command port never applies back-pressure: `cmd_ready` is always high and every command is consumed on the edge where `cmd_valid` is high. A command that cannot run in the current state is dropped. It is not stalled.

Top module: `flash_cmd_seq`

## Requirements
- R1: An address in a hole of a bank (offset at or above the implemented word count), or in no implemented space (a bank index at or above the bank count that is not inside the OTP window), sets the illegal flag (status bit 4). Such a command makes no array request and busy stays low.
- R2: A program, erase or erase-verify address in a main bank whose index (the top two address bits) differs from `bank_id` sets the illegal flag and does nothing else.
- R3: Erase or erase-verify aimed at the OTP window (bank index 3, offset below the OTP size) is illegal. A program aimed at the OTP window is illegal while `otp_unlock` is low and is carried out while it is high.
- R4: A program reads the word, then pulses and verify-reads until the word equals the old value ANDed with the data. If the word still fails after the pulse limit, the program-fail flag (status bit 5) is set, with exactly that many pulses issued.
- R5: An erase pulses the sector and reads back all of its words until every word is all ones. If the sector still fails after the pulse limit, the erase-fail flag (status bit 6) is set.
- R6: Erase-verify (code 3) issues no pulses. It reads the sector from its lowest word and sets the erase-fail flag at the first word that is not all ones.
- R7: Busy (status bit 0) is high from acceptance of a legal program, erase or erase-verify until it completes, including time spent suspended. Otherwise busy is low.
- R8: Program-active (bit 1) and erase-active (bit 2) are high while their operation runs. Suspend (code 4) clears them at the next request boundary and sets the suspended bit (bit 3). Resume (code 5) restores them and continues with the pulse count kept.
- R9: A program that asks for a 1 where the array holds a 0 sets the bad-data flag (bit 7), issues no pulse and leaves the array unchanged. Only clear-status clears this flag.
- R10: While busy, program (code 1), erase (code 2), erase-verify (code 3) and set-limit commands are dropped and the array is not changed by them.
- R11: The pulse limit resets to 8 and is changed by set-limit (code 7, low four data bits) while idle. The pulse count restarts at every new command.
- R12: All status bits reset to 0. Bits 15:8 always read 0. Clear-status (code 6) clears bits 4 to 7 in any state.
- R13: `cmd_ready` is always high. Suspend while idle and resume while not suspended have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken (always high) |
| cmd_code | input | 3 | 1 program, 2 erase, 3 erase-verify, 4 suspend, 5 resume, 6 clear-status, 7 set-limit |
| cmd_addr | input | 12 | Word address |
| cmd_data | input | 16 | Program data or new pulse limit |
| bank_id | input | 2 | Bank the software has selected |
| otp_unlock | input | 1 | Allows programming of the OTP window |
| arr_req | output | 1 | Single-cycle array request |
| arr_op | output | 2 | 0 read, 1 program pulse, 2 sector erase pulse |
| arr_addr | output | 12 | Array word address |
| arr_wdata | output | 16 | Program data |
| arr_ack | input | 1 | Array has finished the request |
| arr_rdata | input | 16 | Read data, valid with the acknowledge |
| status | output | 16 | Status word |

## Verification
Programs are driven with arrays that accept the first pulse, that need three pulses, and that never accept. These separate a clean pass, a retry that still passes, and the fail flag after exactly the limit, both at the default limit and at a reduced one. Erases are run on a sector that clears on the second pulse and on one that never clears. Erase-verify is run on a clean sector and on a dirty one, where the read count shows that it stops at the first bad word. Addresses are chosen to hit each illegal case once and the matching legal neighbour. A long erase is suspended, offered a program that must be dropped, and resumed, so that the frozen and restored flags and the carried pulse count are seen.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_ERASE  = 3'd2,
    CMD_EVFY   = 3'd3,
    CMD_SUSP   = 3'd4,
    CMD_RESUME = 3'd5,
    CMD_CLR    = 3'd6,
    CMD_SETMAX = 3'd7
  } cmd_e;

  typedef enum logic [1:0] {
    AOP_READ  = 2'd0,
    AOP_PROG  = 2'd1,
    AOP_ERASE = 2'd2
  } aop_e;

  typedef enum logic [3:0] {
    S_IDLE, S_PCHK, S_PCHK_W, S_PPUL, S_PPUL_W, S_PVRD, S_PVRD_W,
    S_EPUL, S_EPUL_W, S_EVRD, S_EVRD_W, S_SUSP
  } seq_st_e;

  localparam int STAT_W   = 16;
  localparam int STICKY_N = 4;
endpackage

// File: rtl/fcs_addr_chk.sv
module fcs_addr_chk #(
  parameter int ADDR_W     = 12,
  parameter int BANK_BITS  = 2,
  parameter int NUM_BANKS  = 2,
  parameter int IMPL_WORDS = 768,
  parameter int OTP_WORDS  = 16
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 is_erase,
  input  logic [BANK_BITS-1:0] bank_id,
  input  logic                 otp_unlock,
  output logic                 illegal
);
  localparam int OFF_W = ADDR_W - BANK_BITS;
  localparam logic [OFF_W-1:0]     IMPL_L = OFF_W'(IMPL_WORDS);
  localparam logic [OFF_W-1:0]     OTP_L  = OFF_W'(OTP_WORDS);
  localparam logic [BANK_BITS-1:0] OTP_B  = '1;
  localparam logic [BANK_BITS:0]   NB_L   = (BANK_BITS+1)'(NUM_BANKS);

  logic [BANK_BITS-1:0] bank;
  logic [OFF_W-1:0]     off;
  logic in_main, in_otp, hole, unimpl, wrong_bank, wrong_region, locked;

  assign bank = addr[ADDR_W-1 -: BANK_BITS];
  assign off  = addr[OFF_W-1:0];

  always_comb begin
    in_main      = ({1'b0, bank} < NB_L);
    in_otp       = (bank == OTP_B) && (off < OTP_L);
    hole         = in_main && (off >= IMPL_L);
    unimpl       = !in_main && !in_otp;
    wrong_bank   = in_main && (bank != bank_id);
    wrong_region = in_otp && is_erase;
    locked       = in_otp && !is_erase && !otp_unlock;
    illegal      = hole | unimpl | wrong_bank | wrong_region | locked;
  end
endmodule

// File: rtl/fcs_status.sv
module fcs_status
  import fcs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [STICKY_N-1:0] set_vec,
  input  logic                clr,
  input  logic                busy,
  input  logic                pgm_act,
  input  logic                ers_act,
  input  logic                susp,
  output logic [STAT_W-1:0]   word
);
  logic [STICKY_N-1:0] sticky;

  for (genvar i = 0; i < STICKY_N; i++) begin : g_sticky
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          sticky[i] <= 1'b0;
      else if (set_vec[i]) sticky[i] <= 1'b1;
      else if (clr)        sticky[i] <= 1'b0;
    end
  end

  assign word = {{(STAT_W-4-STICKY_N){1'b0}}, sticky, susp, ers_act, pgm_act, busy};
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 16,
  parameter int BANK_BITS  = 2,
  parameter int NUM_BANKS  = 2,
  parameter int IMPL_WORDS = 768,
  parameter int SECT_WORDS = 64,
  parameter int OTP_WORDS  = 16,
  parameter int PULSE_W    = 4,
  parameter int MAX_RST    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [2:0]           cmd_code,
  input  logic [ADDR_W-1:0]    cmd_addr,
  input  logic [DATA_W-1:0]    cmd_data,
  input  logic [BANK_BITS-1:0] bank_id,
  input  logic                 otp_unlock,
  output logic                 arr_req,
  output logic [1:0]           arr_op,
  output logic [ADDR_W-1:0]    arr_addr,
  output logic [DATA_W-1:0]    arr_wdata,
  input  logic                 arr_ack,
  input  logic [DATA_W-1:0]    arr_rdata,
  output logic [15:0]          status
);
  localparam int SECT_BITS = $clog2(SECT_WORDS);

  cmd_e                 code;
  seq_st_e              state, nxt, ret_q, ret_n;
  cmd_e                 op_q, op_n;
  logic [ADDR_W-1:0]    addr_q, addr_n, sect_base;
  logic [DATA_W-1:0]    data_q, data_n, tgt_q, tgt_n;
  logic [SECT_BITS-1:0] idx_q, idx_n;
  logic [PULSE_W-1:0]   pcnt_q, pcnt_n, max_q, max_n, eff_max;
  logic                 pend_q, pend_n;
  logic                 illegal, is_erase, issue;
  logic                 set_ill, set_pgv, set_ev, set_inv, clr_st;
  logic                 busy, pgm_act, ers_act, susp;

  assign code      = cmd_e'(cmd_code);
  assign cmd_ready = 1'b1;
  assign is_erase  = (code == CMD_ERASE) || (code == CMD_EVFY);
  assign sect_base = {cmd_addr[ADDR_W-1:SECT_BITS], {SECT_BITS{1'b0}}};
  assign eff_max   = (max_q == '0) ? PULSE_W'(1) : max_q;

  fcs_addr_chk #(
    .ADDR_W(ADDR_W), .BANK_BITS(BANK_BITS), .NUM_BANKS(NUM_BANKS),
    .IMPL_WORDS(IMPL_WORDS), .OTP_WORDS(OTP_WORDS)
  ) u_chk (
    .addr(cmd_addr), .is_erase(is_erase), .bank_id(bank_id),
    .otp_unlock(otp_unlock), .illegal(illegal)
  );

  always_comb begin
    issue = (state == S_PCHK) || (state == S_PPUL) || (state == S_PVRD) ||
            (state == S_EPUL) || (state == S_EVRD);
  end

  // next-state and operation bookkeeping
  always_comb begin
    nxt = state;   ret_n = ret_q;   op_n = op_q;   addr_n = addr_q;
    data_n = data_q; tgt_n = tgt_q; idx_n = idx_q; pcnt_n = pcnt_q;
    max_n = max_q;   pend_n = pend_q;
    set_ill = 1'b0; set_pgv = 1'b0; set_ev = 1'b0; set_inv = 1'b0;
    clr_st  = cmd_valid && (code == CMD_CLR);

    if (cmd_valid) begin
      if (state == S_IDLE) begin
        case (code)
          CMD_PROG, CMD_ERASE, CMD_EVFY: begin
            if (illegal) set_ill = 1'b1;
            else begin
              op_n   = code;
              pcnt_n = '0;
              idx_n  = '0;
              data_n = cmd_data;
              addr_n = (code == CMD_PROG) ? cmd_addr : sect_base;
              nxt    = (code == CMD_PROG)  ? S_PCHK :
                       (code == CMD_ERASE) ? S_EPUL : S_EVRD;
            end
          end
          CMD_SETMAX: max_n = cmd_data[PULSE_W-1:0];
          default: ;
        endcase
      end else if (code == CMD_SUSP && state != S_SUSP) begin
        pend_n = 1'b1;
      end else if (code == CMD_RESUME && state == S_SUSP) begin
        nxt = ret_q;
      end
    end

    case (state)
      S_PCHK, S_PPUL, S_PVRD, S_EPUL, S_EVRD: begin
        if (pend_q) begin
          ret_n  = state;
          nxt    = S_SUSP;
          pend_n = 1'b0;
        end else begin
          case (state)
            S_PCHK:  nxt = S_PCHK_W;
            S_PPUL:  nxt = S_PPUL_W;
            S_PVRD:  nxt = S_PVRD_W;
            S_EPUL:  nxt = S_EPUL_W;
            default: nxt = S_EVRD_W;
          endcase
          if (state == S_PPUL || state == S_EPUL) pcnt_n = pcnt_q + 1'b1;
        end
      end
      S_PCHK_W: if (arr_ack) begin
        if (|(data_q & ~arr_rdata)) begin
          set_inv = 1'b1;
          nxt     = S_IDLE;
        end else begin
          tgt_n = arr_rdata & data_q;
          nxt   = S_PPUL;
        end
      end
      S_PPUL_W: if (arr_ack) nxt = S_PVRD;
      S_PVRD_W: if (arr_ack) begin
        if (arr_rdata == tgt_q) nxt = S_IDLE;
        else if (pcnt_q >= eff_max) begin
          set_pgv = 1'b1;
          nxt     = S_IDLE;
        end else nxt = S_PPUL;
      end
      S_EPUL_W: if (arr_ack) begin
        idx_n = '0;
        nxt   = S_EVRD;
      end
      S_EVRD_W: if (arr_ack) begin
        if (arr_rdata != '1) begin
          if (op_q == CMD_EVFY || pcnt_q >= eff_max) begin
            set_ev = 1'b1;
            nxt    = S_IDLE;
          end else nxt = S_EPUL;
        end else if (idx_q == '1) begin
          nxt = S_IDLE;
        end else begin
          idx_n = idx_q + 1'b1;
          nxt   = S_EVRD;
        end
      end
      default: ;
    endcase

    if (nxt == S_IDLE) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ret_q  <= S_IDLE;
      op_q   <= CMD_NOP;
      addr_q <= '0;
      data_q <= '0;
      tgt_q  <= '0;
      idx_q  <= '0;
      pcnt_q <= '0;
      max_q  <= PULSE_W'(MAX_RST);
      pend_q <= 1'b0;
    end else begin
      state  <= nxt;
      ret_q  <= ret_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      data_q <= data_n;
      tgt_q  <= tgt_n;
      idx_q  <= idx_n;
      pcnt_q <= pcnt_n;
      max_q  <= max_n;
      pend_q <= pend_n;
    end
  end

  // array request drive
  always_comb begin
    arr_req   = issue && !pend_q;
    arr_wdata = data_q;
    arr_addr  = (state == S_EVRD) ? {addr_q[ADDR_W-1:SECT_BITS], idx_q} : addr_q;
    case (state)
      S_PPUL:  arr_op = AOP_PROG;
      S_EPUL:  arr_op = AOP_ERASE;
      default: arr_op = AOP_READ;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign susp    = (state == S_SUSP);
  assign pgm_act = busy && !susp && (op_q == CMD_PROG);
  assign ers_act = busy && !susp && (op_q == CMD_ERASE);

  fcs_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_vec({set_inv, set_ev, set_pgv, set_ill}),
    .clr(clr_st), .busy(busy), .pgm_act(pgm_act), .ers_act(ers_act),
    .susp(susp), .word(status)
  );
endmodule

// File: rtl/fcs_sva.sv
module fcs_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_code,
  input logic        arr_req,
  input logic [15:0] status
);
  a_r1_illegal_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[4]) |-> !status[0]);

  a_r7_busy_covers_activity: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] || status[2] || status[3]) |-> status[0]);

  a_r8_one_active_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[1] && status[2]));

  a_r8_suspend_clears_active: assert property (@(posedge clk) disable iff (!rst_n)
    status[3] |-> (!status[1] && !status[2]));

  a_r9_bad_data_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[7] && !(cmd_valid && cmd_code == 3'd6)) |=> status[7]);

  a_r10_no_request_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] |-> !arr_req);

  a_r4_single_cycle_request: assert property (@(posedge clk) disable iff (!rst_n)
    arr_req |=> !arr_req);
endmodule

bind flash_cmd_seq fcs_sva u_sva (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .arr_req(arr_req), .status(status)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
  localparam logic [2:0] C_PROG = 3'd1, C_ERASE = 3'd2, C_EVFY = 3'd3, C_SUSP = 3'd4,
                         C_RES = 3'd5, C_CLR = 3'd6, C_SETMAX = 3'd7;
  localparam logic [15:0] B_BUSY = 16'h0001, B_PGM = 16'h0002, B_ERS = 16'h0004,
                          B_SUSP = 16'h0008, B_ILL = 16'h0010, B_PGV = 16'h0020,
                          B_EV = 16'h0040, B_INV = 16'h0080;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [2:0] cmd_code = '0;
  logic [11:0] cmd_addr = '0;
  logic [15:0] cmd_data = '0;
  logic [1:0] bank_id = '0;
  logic otp_unlock = 1'b0;
  logic arr_req, arr_ack = 1'b0;
  logic [1:0] arr_op;
  logic [11:0] arr_addr;
  logic [15:0] arr_wdata, arr_rdata = '0, status;

  always #2 clk = ~clk;

  flash_cmd_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .bank_id(bank_id), .otp_unlock(otp_unlock), .arr_req(arr_req),
    .arr_op(arr_op), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
    .arr_ack(arr_ack), .arr_rdata(arr_rdata), .status(status)
  );

  // behavioural array: unwritten words read as all ones
  logic [15:0] mem [int];
  int prog_need = 1, erase_need = 1, seen = 0;
  int n_pp = 0, n_ep = 0, n_rd = 0;
  int n_checks = 0, n_fail = 0;

  function automatic logic [15:0] rd(int a);
    return mem.exists(a) ? mem[a] : 16'hFFFF;
  endfunction

  always @(posedge clk) begin
    arr_ack <= 1'b0;
    if (arr_req) begin
      arr_ack <= 1'b1;
      case (arr_op)
        2'd0: begin arr_rdata <= rd(int'(arr_addr)); n_rd++; end
        2'd1: begin
          n_pp++; seen++;
          if (seen >= prog_need) mem[int'(arr_addr)] = rd(int'(arr_addr)) & arr_wdata;
        end
        2'd2: begin
          n_ep++; seen++;
          if (seen >= erase_need)
            for (int k = 0; k < 64; k++) mem.delete(int'({arr_addr[11:6], 6'd0}) + k);
        end
        default: ;
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: driver queues expected status, monitor compares
  typedef struct { logic [15:0] val; string req; } sb_item_t;
  sb_item_t sb_q[$];
  event sb_ev;

  initial begin
    forever begin
      @(sb_ev);
      while (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        chk(status === it.val, it.req, "status", status, it.val);
      end
    end
  end

  task automatic expect_status(input logic [15:0] v, input string req);
    sb_item_t it;
    it.val = v; it.req = req;
    sb_q.push_back(it);
    ->sb_ev;
    #1;
  endtask

  task automatic clear_counts(input int pn, input int en);
    n_pp = 0; n_ep = 0; n_rd = 0; seen = 0; prog_need = pn; erase_need = en;
  endtask

  task automatic send(input logic [2:0] c, input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    chk(cmd_ready === 1'b1, "R13", "cmd_ready", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_code = c; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (status[0] !== 1'b0 && n < 5000) begin @(negedge clk); n++; end
    chk(status[0] === 1'b0, req, "completion", status[0], 0);
  endtask

  task automatic clr_status();
    send(C_CLR, '0, '0);
    expect_status(16'h0000, "R12");
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "timeout", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_status(16'h0000, "R12");
    rst_n = 1'b1;
    @(negedge clk);
    expect_status(16'h0000, "R12");

    // R4 first-pulse pass, with R7/R8 active flags
    clear_counts(1, 1);
    send(C_PROG, 12'h005, 16'h1234);
    expect_status(B_BUSY | B_PGM, "R7");
    wait_idle("R4");
    expect_status(16'h0000, "R4");
    chk(rd(5) == 16'h1234, "R4", "word 0x005", rd(5), 16'h1234);
    chk(n_pp == 1, "R4", "pulses", n_pp, 1);

    // R4 retry
    clear_counts(3, 1);
    send(C_PROG, 12'h006, 16'h00F0);
    wait_idle("R4");
    expect_status(16'h0000, "R4");
    chk(n_pp == 3, "R4", "retry pulses", n_pp, 3);

    // R4/R11 failure after default limit 8
    clear_counts(99, 1);
    send(C_PROG, 12'h007, 16'h0000);
    wait_idle("R4");
    expect_status(B_PGV, "R4");
    chk(n_pp == 8, "R11", "default limit pulses", n_pp, 8);

    // R9 bad data
    clear_counts(1, 1);
    send(C_PROG, 12'h005, 16'h1235);
    wait_idle("R9");
    expect_status(B_PGV | B_INV, "R9");
    chk(n_pp == 0, "R9", "pulses", n_pp, 0);
    chk(rd(5) == 16'h1234, "R9", "word unchanged", rd(5), 16'h1234);
    send(C_PROG, 12'h008, 16'hFF00);
    wait_idle("R9");
    expect_status(B_PGV | B_INV, "R9");
    clr_status();

    // R11 reduced limit, counter restart
    send(C_SETMAX, '0, 16'h0003);
    clear_counts(99, 1);
    send(C_PROG, 12'h009, 16'h0000);
    wait_idle("R11");
    chk(n_pp == 3, "R11", "limit 3 pulses", n_pp, 3);
    clear_counts(99, 1);
    send(C_PROG, 12'h00A, 16'h0000);
    wait_idle("R11");
    chk(n_pp == 3, "R11", "second command pulses", n_pp, 3);
    expect_status(B_PGV, "R11");
    clr_status();
    send(C_SETMAX, '0, 16'h0008);

    // R1 hole and unimplemented space
    clear_counts(1, 1);
    send(C_PROG, 12'h320, 16'h0000);
    expect_status(B_ILL, "R1");
    clr_status();
    send(C_PROG, 12'h805, 16'h0000);
    expect_status(B_ILL, "R1");
    clr_status();
    send(C_ERASE, 12'hC20, 16'h0000);
    expect_status(B_ILL, "R1");
    chk(n_pp + n_ep + n_rd == 0, "R1", "array requests", n_pp + n_ep + n_rd, 0);
    clr_status();

    // R2 bank mismatch
    send(C_PROG, 12'h405, 16'hABCD);
    expect_status(B_ILL, "R2");
    chk(!mem.exists(12'h405), "R2", "word written", 1, 0);
    clr_status();
    bank_id = 2'd1;
    send(C_PROG, 12'h405, 16'hABCD);
    wait_idle("R2");
    expect_status(16'h0000, "R2");
    chk(rd(12'h405) == 16'hABCD, "R2", "word 0x405", rd(12'h405), 16'hABCD);
    bank_id = 2'd0;

    // R3 OTP region rules
    send(C_PROG, 12'hC03, 16'h5A5A);
    expect_status(B_ILL, "R3");
    clr_status();
    otp_unlock = 1'b1;
    clear_counts(1, 1);
    send(C_PROG, 12'hC03, 16'h5A5A);
    wait_idle("R3");
    expect_status(16'h0000, "R3");
    chk(rd(12'hC03) == 16'h5A5A, "R3", "OTP word", rd(12'hC03), 16'h5A5A);
    send(C_ERASE, 12'hC00, '0);
    expect_status(B_ILL, "R3");
    clr_status();
    send(C_EVFY, 12'hC00, '0);
    expect_status(B_ILL, "R3");
    clr_status();
    otp_unlock = 1'b0;

    // R6 erase-verify
    clear_counts(1, 1);
    send(C_EVFY, 12'h010, '0);
    expect_status(B_BUSY, "R7");
    wait_idle("R6");
    expect_status(B_EV, "R6");
    chk(n_rd == 6, "R6", "reads to first bad word", n_rd, 6);
    chk(n_ep == 0, "R6", "pulses", n_ep, 0);
    clr_status();
    clear_counts(1, 1);
    send(C_EVFY, 12'h080, '0);
    wait_idle("R6");
    expect_status(16'h0000, "R6");
    chk(n_rd == 64, "R6", "clean sector reads", n_rd, 64);

    // R5 erase passing on second pulse
    clear_counts(1, 2);
    send(C_ERASE, 12'h00C, '0);
    expect_status(B_BUSY | B_ERS, "R8");
    wait_idle("R5");
    expect_status(16'h0000, "R5");
    chk(n_ep == 2, "R5", "erase pulses", n_ep, 2);
    chk(rd(5) == 16'hFFFF, "R5", "word after erase", rd(5), 16'hFFFF);

    // R5 erase failure
    clear_counts(1, 99);
    send(C_PROG, 12'h045, 16'h0000);
    wait_idle("R5");
    clear_counts(1, 99);
    send(C_ERASE, 12'h040, '0);
    wait_idle("R5");
    expect_status(B_EV, "R5");
    chk(n_ep == 8, "R5", "erase pulses at limit", n_ep, 8);
    clr_status();

    // R8 suspend/resume, R10 drop while busy
    clear_counts(1, 99);
    send(C_ERASE, 12'h040, '0);
    repeat (10) @(negedge clk);
    send(C_SUSP, '0, '0);
    for (int n = 0; n < 100 && status[3] !== 1'b1; n++) @(negedge clk);
    expect_status(B_BUSY | B_SUSP, "R8");
    begin
      int frozen;
      frozen = n_ep;
      repeat (30) @(negedge clk);
      chk(n_ep == frozen, "R8", "pulses while suspended", n_ep, frozen);
    end
    send(C_PROG, 12'h0C0, 16'h0000);
    repeat (10) @(negedge clk);
    chk(!mem.exists(12'h0C0), "R10", "dropped program", 1, 0);
    expect_status(B_BUSY | B_SUSP, "R10");
    send(C_RES, '0, '0);
    expect_status(B_BUSY | B_ERS, "R8");
    wait_idle("R8");
    expect_status(B_EV, "R8");
    chk(n_ep == 8, "R8", "pulses across suspend", n_ep, 8);
    clr_status();

    // R10 erase dropped during a running program
    clear_counts(99, 1);
    send(C_PROG, 12'h0C1, 16'h0000);
    repeat (5) @(negedge clk);
    send(C_ERASE, 12'h0C0, '0);
    wait_idle("R10");
    expect_status(B_PGV, "R10");
    chk(n_ep == 0, "R10", "erase pulses", n_ep, 0);
    clr_status();

    // R13 suspend while idle, resume while not suspended
    send(C_SUSP, '0, '0);
    send(C_RES, '0, '0);
    expect_status(16'h0000, "R13");
    clear_counts(1, 1);
    send(C_PROG, 12'h0C2, 16'h1111);
    wait_idle("R13");
    expect_status(16'h0000, "R13");
    chk(rd(12'h0C2) == 16'h1111, "R13", "program after idle suspend", rd(12'h0C2), 16'h1111);

    summary();
  end
endmodule